// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds or subtracts two 64-bit operands. The carry chain can be cut at lane boundaries, so the datapath runs as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. Each lane computes on its own, and carries never cross from one lane into the next. Subtraction inverts the second operand and feeds a carry of one into the lowest byte of every lane. This adds the two's-complement negation of the second operand.

Each lane tests for overflow under either a signed or an unsigned reading of its bits. In wrap mode the lane keeps its modulo result. In saturate mode an overflowing lane is replaced by the limit it ran past. The overflow flag of a lane is copied onto every byte position of that lane. The result and the flags are registered, so they appear one clock after the operands and controls are presented.

There is no state machine. The block is a combinational datapath followed by one output register stage.

Top module: `psa_simd_adder`

## Requirements
- R1: `lane_sel` picks the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes, and 3 gives one 64-bit lane. Lane k takes operand bits [k*w+w-1 : k*w].
- R2: No carry or borrow passes from one lane into the next lane.
- R3: When `do_sub` is 1, each lane computes a minus b modulo 2^w. This is done by adding the inverted b plus one.
- R4: Signed add (`is_signed`=1, `do_sub`=0) flags a lane only when both operand signs are equal and the result sign differs from them.
- R5: Signed subtract flags a lane only when the operand signs differ and the result sign differs from the sign of a.
- R6: Unsigned add flags a lane on a carry out of its top bit. Unsigned subtract flags a lane when b is greater than a, which is a borrow.
- R7: When `saturate` is 0, every lane returns its modulo result, even when its flag is set.
- R8: Signed saturation sets a flagged lane to the largest positive value (0x7F..F) when a is non-negative. It sets the lane to the most negative value (0x80..0) when a is negative.
- R9: Unsigned saturation sets a flagged lane to all ones on an add and to zero on a subtract.
- R10: Bit j of `ovf_q` is the flag of the lane that contains byte j. All bytes of one lane carry the same flag value.
- R11: `sum_q` and `ovf_q` are registered one clock after the inputs. While `rst_n` is low, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand, the subtrahend when subtracting |
| lane_sel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| do_sub | input | 1 | 1 = subtract, 0 = add |
| is_signed | input | 1 | 1 = signed overflow rules, 0 = unsigned |
| saturate | input | 1 | 1 = clamp flagged lanes, 0 = wrap |
| sum_q | output | 64 | Registered lane results |
| ovf_q | output | 8 | Registered per-byte overflow flags |

## Verification
Both outputs come from a single register stage. A vector is driven on a falling edge, captured on the next rising edge, and becomes visible on `sum_q` and `ovf_q` right after that edge. The bench therefore drives on a falling edge and compares on the following falling edge, which is exactly one cycle later. This keeps each result paired with its own vector. The assertions inside the RTL check the combinational next-state values in the same cycle as the inputs that produce them.

// File: rtl/psa_pkg.sv
package psa_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_w_e;
endpackage

// File: rtl/psa_byte_slice.sv
module psa_byte_slice #(
    parameter int unsigned BW = 8
) (
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic          sub,
    input  logic          cin,
    output logic [BW-1:0] sum,
    output logic          cout,
    output logic          a_msb,
    output logic          bx_msb
);
    logic [BW-1:0] bx;

    always_comb begin
        bx            = sub ? ~b : b;
        {cout, sum}   = {1'b0, a} + {1'b0, bx} + {{BW{1'b0}}, cin};
        a_msb         = a[BW-1];
        bx_msb        = bx[BW-1];
    end
endmodule

// File: rtl/psa_lane_map.sv
module psa_lane_map
    import psa_pkg::*;
#(
    parameter int unsigned NBYTES = 8,
    localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  lane_w_e                      lane,
    output logic [NBYTES-1:0]            is_first,
    output logic [NBYTES-1:0][IDX_W-1:0] top_idx
);
    logic [IDX_W-1:0] span_m1;

    always_comb begin
        unique case (lane)
            LANE_B8:  span_m1 = IDX_W'(0);
            LANE_B16: span_m1 = IDX_W'(1);
            LANE_B32: span_m1 = IDX_W'(3);
            LANE_B64: span_m1 = IDX_W'(7);
            default:  span_m1 = IDX_W'(0);
        endcase
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_map
        always_comb begin
            is_first[i] = ((IDX_W'(i) & span_m1) == '0);
            top_idx[i]  = IDX_W'(i) | span_m1;
        end
    end
endmodule

// File: rtl/psa_lane_clamp.sv
module psa_lane_clamp #(
    parameter int unsigned BW = 8
) (
    input  logic [BW-1:0] raw,
    input  logic          sat_en,
    input  logic          sgn,
    input  logic          sub,
    input  logic          lane_ovf,
    input  logic          lane_neg,
    input  logic          is_top,
    output logic [BW-1:0] out
);
    logic [BW-1:0] limit;

    always_comb begin
        if (sgn) begin
            if (lane_neg)
                limit = is_top ? {1'b1, {(BW-1){1'b0}}} : '0;
            else
                limit = is_top ? {1'b0, {(BW-1){1'b1}}} : '1;
        end else begin
            limit = sub ? '0 : '1;
        end
        out = (sat_en && lane_ovf) ? limit : raw;
    end
endmodule

// File: rtl/psa_simd_adder.sv
module psa_simd_adder
    import psa_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned NBYTES = DATA_W / BYTE_W,
    localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        lane_sel,
    input  logic              do_sub,
    input  logic              is_signed,
    input  logic              saturate,
    output logic [DATA_W-1:0] sum_q,
    output logic [NBYTES-1:0] ovf_q
);
    lane_w_e                      lane;
    logic [NBYTES-1:0]            is_first;
    logic [NBYTES-1:0][IDX_W-1:0] top_idx;
    logic [NBYTES-1:0]            cin, cout, a_msb, bx_msb, byte_ovf;
    logic [NBYTES-1:0]            lane_ovf, lane_neg, is_top;
    logic [NBYTES-1:0]            chain;
    logic [DATA_W-1:0]            raw_sum, res_d;

    assign lane  = lane_w_e'(lane_sel);
    assign chain = {cout[NBYTES-2:0], do_sub};

    psa_lane_map #(.NBYTES(NBYTES)) u_map (
        .lane     (lane),
        .is_first (is_first),
        .top_idx  (top_idx)
    );

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign cin[i] = is_first[i] ? do_sub : chain[i];

        psa_byte_slice #(.BW(BYTE_W)) u_slice (
            .a      (op_a[i*BYTE_W +: BYTE_W]),
            .b      (op_b[i*BYTE_W +: BYTE_W]),
            .sub    (do_sub),
            .cin    (cin[i]),
            .sum    (raw_sum[i*BYTE_W +: BYTE_W]),
            .cout   (cout[i]),
            .a_msb  (a_msb[i]),
            .bx_msb (bx_msb[i])
        );

        always_comb begin
            if (is_signed)
                byte_ovf[i] = (a_msb[i] == bx_msb[i]) &&
                              (raw_sum[i*BYTE_W + BYTE_W - 1] != a_msb[i]);
            else
                byte_ovf[i] = do_sub ? ~cout[i] : cout[i];
            lane_ovf[i] = byte_ovf[top_idx[i]];
            lane_neg[i] = a_msb[top_idx[i]];
            is_top[i]   = (top_idx[i] == IDX_W'(i));
        end

        psa_lane_clamp #(.BW(BYTE_W)) u_clamp (
            .raw      (raw_sum[i*BYTE_W +: BYTE_W]),
            .sat_en   (saturate),
            .sgn      (is_signed),
            .sub      (do_sub),
            .lane_ovf (lane_ovf[i]),
            .lane_neg (lane_neg[i]),
            .is_top   (is_top[i]),
            .out      (res_d[i*BYTE_W +: BYTE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            ovf_q <= '0;
        end else begin
            sum_q <= res_d;
            ovf_q <= lane_ovf;
        end
    end

    AST_BYTE_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
        (lane == LANE_B8 && !saturate) |->
        res_d[15:8] == (do_sub ? 8'(op_a[15:8] - op_b[15:8]) : 8'(op_a[15:8] + op_b[15:8]))); // R2
    AST_WRAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !saturate |-> res_d == raw_sum); // R7
    AST_SGN_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (saturate && is_signed && lane == LANE_B8 && lane_ovf[0]) |->
        (res_d[7:0] == 8'h7F || res_d[7:0] == 8'h80)); // R8
    AST_UNS_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (saturate && !is_signed && lane == LANE_B8 && lane_ovf[0]) |->
        res_d[7:0] == (do_sub ? 8'h00 : 8'hFF)); // R9
    AST_LANE_FLAG_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        lane == LANE_B16 |->
        (lane_ovf[0] == lane_ovf[1] && lane_ovf[2] == lane_ovf[3])); // R10
    AST_FULL_FLAG_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        lane == LANE_B64 |-> ($countones(lane_ovf) == 0 || $countones(lane_ovf) == NBYTES)); // R10
endmodule

// File: tb/psa_simd_adder_bench.sv
`timescale 1ns/1ps
module psa_simd_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [1:0]  lane_sel = '0;
    logic        do_sub = 1'b0, is_signed = 1'b0, saturate = 1'b0;
    logic [63:0] sum_q;
    logic [7:0]  ovf_q;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    psa_simd_adder u_psa_simd_adder (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .lane_sel(lane_sel),
        .do_sub(do_sub), .is_signed(is_signed), .saturate(saturate),
        .sum_q(sum_q), .ovf_q(ovf_q)
    );

    function automatic logic [71:0] ref_calc(logic [63:0] a, logic [63:0] b, logic [1:0] sel,
                                             logic sub, logic sgn, logic sat);
        int w = 8 << sel;
        int nl = 64 / w;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [63:0] res = '0;
        logic [7:0]  flg = '0;
        for (int l = 0; l < nl; l++) begin
            logic [63:0] la = (a >> (l * w)) & mask;
            logic [63:0] lb = (b >> (l * w)) & mask;
            logic [64:0] wide = {1'b0, la} + {1'b0, lb};
            logic [63:0] r = (sub ? (la - lb) : (la + lb)) & mask;
            logic uo = sub ? (la < lb) : wide[w];
            logic sa = la[w-1];
            logic sb = lb[w-1];
            logic sr = r[w-1];
            logic so = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
            logic ov = sgn ? so : uo;
            if (sat && ov) begin
                if (sgn) r = sa ? (64'd1 << (w - 1)) : (mask >> 1);
                else     r = sub ? 64'd0 : mask;
            end
            res = res | (r << (l * w));
            for (int k = 0; k < w / 8; k++) flg[l * (w / 8) + k] = ov;
        end
        return {flg, res};
    endfunction

    task automatic check(string tag, logic [63:0] exp_r, logic [7:0] exp_f);
        total++;
        if (sum_q !== exp_r || ovf_q !== exp_f) begin
            bad++;
            $display("FAIL %s: sum=%h ovf=%h expected sum=%h ovf=%h", tag, sum_q, ovf_q, exp_r, exp_f);
        end
    endtask

    task automatic run(string tag, logic [63:0] a, logic [63:0] b, logic [1:0] sel,
                       logic sub, logic sgn, logic sat);
        logic [71:0] e;
        @(negedge clk);
        op_a = a; op_b = b; lane_sel = sel; do_sub = sub; is_signed = sgn; saturate = sat;
        e = ref_calc(a, b, sel, sub, sgn, sat);
        @(negedge clk);
        check(tag, e[63:0], e[71:64]);
    endtask

    function automatic logic [63:0] pick_operand();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) begin
            case ($urandom % 6)
                0: v[k*8 +: 8] = 8'h7F;
                1: v[k*8 +: 8] = 8'h80;
                2: v[k*8 +: 8] = 8'hFF;
                3: v[k*8 +: 8] = 8'h00;
                default: v[k*8 +: 8] = 8'($urandom);
            endcase
        end
        return v;
    endfunction

    initial begin
        #(8ns * 200000);
        total++; bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        op_a = '1; op_b = '1; saturate = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 reset", 64'd0, 8'd0);
        rst_n = 1'b1;
        // R1/R2: byte lanes, each FF+01 wraps to 00 without carrying upward
        run("R2 byte carry", 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 0, 0, 0);
        run("R1 16-bit lanes", 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd1, 0, 0, 0);
        run("R1 32-bit borrow", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd2, 1, 0, 0);
        run("R1 64-bit lane", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 0, 0, 0);
        run("R3 subtract", 64'h0706_0504_0302_0100, 64'h0101_0101_0101_0101, 2'd0, 1, 0, 0);
        run("R4 signed add pos", 64'h0000_0000_0000_007F, 64'h0000_0000_0000_0001, 2'd0, 0, 1, 0);
        run("R4 signed add neg", 64'h0000_0000_0000_0080, 64'h0000_0000_0000_00FF, 2'd0, 0, 1, 0);
        run("R5 signed sub", 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001, 2'd1, 1, 1, 0);
        run("R6 unsigned add carry", 64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 2'd2, 0, 0, 0);
        run("R6 unsigned borrow", 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 2'd1, 1, 0, 0);
        run("R7 wrap keeps modulo", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 0, 1, 0);
        run("R8 signed clamp high", 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 0, 1, 1);
        run("R8 signed clamp low", 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 2'd2, 1, 1, 1);
        run("R9 unsigned clamp ones", 64'h00FF_00FF_00FF_00FF, 64'h00FF_00FF_00FF_00FF, 2'd0, 0, 0, 1);
        run("R9 unsigned clamp zero", 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0005, 2'd1, 1, 0, 1);
        run("R10 flag spread", 64'h0000_7FFF_0000_0000, 64'h0000_0001_0000_0000, 2'd1, 0, 1, 1);
        for (int n = 0; n < 3000; n++) begin
            run("R1 random", pick_operand(), pick_operand(), 2'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom));
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset again", 64'd0, 8'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule